// File: doc/BRIEF.md
# DMA Dispatcher Control, Status and Response Unit

This block is the register front end of a DMA dispatcher. It holds the control word that software writes to steer the dispatcher, and it assembles a status word from its own state and from signals that the descriptor queue and the data mover report. Each time the data mover finishes a descriptor, it hands over a completion event. The block stores that event as a two-word response in a small FIFO and decides whether the event raises an interrupt or halts descriptor fetching.

Software reads the oldest response through two register words: the byte count, then the status. Reading the status word retires the response. Sticky status bits are cleared by writing ones to them. A soft reset, started from the control word, lasts a fixed number of cycles. While it runs, it is reported in the status word, it flushes the response queue, it clears the control word and the sticky bits, and it drives a reset request to the rest of the dispatcher.

The register port has a single-cycle write and a read whose data is registered: the data appears one cycle after the read request. Word addresses are 0 status, 1 control, 2 response fill level, 3 response byte count, 4 response status. Any other address reads as zero.

Top module: `dma_dispatch_csr`

## Requirements
- R1: After the synchronous reset, the status word reads 0x008 when the mover and queue inputs are low. The control word and the fill level read 0, `irq` is 0, and both `fetch_en` and `cmp_ready` are 1.
- R2: An accepted completion appends one response. The fill level reads in bits 15:0 of word 2. Word 3 returns the byte count of the oldest response. Word 4 returns its error bits in bits 7:0 and its early-termination flag in bit 8.
- R3: Reading word 3 changes nothing. Reading word 4 while responses are queued removes the oldest one, and responses leave in arrival order.
- R4: With RESP_DEPTH responses queued, status bit 4 is set and `cmp_ready` is 0. A completion offered in that state is not queued.
- R5: Status bit 9 (IRQ pending) is set by an accepted completion whose completion-IRQ enable is 1, or whose error bits AND its error-IRQ mask are nonzero. It is not set otherwise, and writing 1 to bit 9 of the status word clears it.
- R6: `irq` is high exactly while IRQ pending is set and control bit 4 (global interrupt enable) is 1.
- R7: With control bit 2 set, an accepted completion with nonzero error bits sets status bit 7 and stopped (bit 5), and drops `fetch_en`. With control bit 2 clear, such a completion sets neither. Writing 1 to status bit 7 releases the stop.
- R8: With control bit 3 set, an accepted completion with its early-termination flag set sets status bit 8 and stopped (bit 5). Writing 1 to status bit 8 clears it.
- R9: Control bit 0 sets stopped (bit 5) and drops `fetch_en`. Control bit 5 drops `fetch_en` without setting stopped. Control reads back what was written, with bit 1 always reading 0.
- R10: Writing 1 to control bit 1 starts a soft reset lasting RST_CYCLES cycles. During the reset, status bit 6 and `mover_rst` are 1, and `cmp_ready` and `fetch_en` are 0. After the reset, the response queue is empty, the control word is 0, and status bits 7, 8 and 9 are 0.
- R11: Status bits 0, 1 and 2 follow `mover_busy`, `dq_empty` and `dq_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| cmp_valid | input | 1 | Completion event offered by the data mover |
| cmp_ready | output | 1 | Completion can be accepted this cycle |
| cmp_bytes | input | 32 | Bytes transferred by the finished descriptor |
| cmp_err | input | 8 | Error bits of the finished descriptor |
| cmp_early | input | 1 | Descriptor ended by early termination |
| cmp_irq_done | input | 1 | Descriptor requests an interrupt on completion |
| cmp_err_irq_mask | input | 8 | Error bits that raise an interrupt for this descriptor |
| mover_busy | input | 1 | Data mover is working |
| dq_empty | input | 1 | Descriptor queue is empty |
| dq_full | input | 1 | Descriptor queue is full |
| fetch_en | output | 1 | Dispatcher may issue further descriptors |
| mover_rst | output | 1 | Soft reset request to the rest of the dispatcher |
| irq | output | 1 | Level interrupt request |

## Verification
Most internal faults in this block show at the ports in the same cycle as their cause or in the next one. A lost or duplicated queue pointer shows up on the next read of word 3 or 4 as a wrong byte count or a wrong response order. A fill counter that drifts shows on the next read of word 2 and also in `cmp_ready`. A sticky bit that sets when it should not drops `fetch_en` or raises `irq` one cycle after the accepted completion. A soft reset counter that is off by a cycle holds `mover_rst` and status bit 6 high for the wrong number of cycles, and one that skips the flush leaves a nonzero fill level after the reset ends.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int DATA_W = 32;
  localparam int ERR_W  = 8;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 6;
  localparam int STAT_W = 10;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RBYTES = 3'd3;
  localparam logic [ADDR_W-1:0] A_RSTAT  = 3'd4;

  // control bit positions
  localparam int C_STOP      = 0;
  localparam int C_RESET     = 1;
  localparam int C_STOP_ERR  = 2;
  localparam int C_STOP_ERLY = 3;
  localparam int C_GIE       = 4;
  localparam int C_HOLD_DESC = 5;

  // status bit positions
  localparam int S_BUSY      = 0;
  localparam int S_DQ_EMPTY  = 1;
  localparam int S_DQ_FULL   = 2;
  localparam int S_RQ_EMPTY  = 3;
  localparam int S_RQ_FULL   = 4;
  localparam int S_STOPPED   = 5;
  localparam int S_RESETTING = 6;
  localparam int S_STOP_ERR  = 7;
  localparam int S_STOP_ERLY = 8;
  localparam int S_IRQ       = 9;

  typedef struct packed {
    logic              early;
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] bytes;
  } resp_entry_t;
endpackage

// File: rtl/dcsr_resp_fifo.sv
module dcsr_resp_fifo
  import dcsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  resp_entry_t      din,
  input  logic             pop,
  output resp_entry_t      head,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  resp_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head  = mem[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/dcsr_reset_seq.sv
module dcsr_reset_seq #(
  parameter int CYCLES = 32,
  parameter int CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        remain <= CNT_W'(CYCLES - 1);
      end
    end else if (remain == '0) begin
      active <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dcsr_event_track.sv
module dcsr_event_track
  import dcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_all,
  input  logic             accept,
  input  logic [ERR_W-1:0] err,
  input  logic             early,
  input  logic             irq_done,
  input  logic [ERR_W-1:0] err_mask,
  input  logic             halt_on_err,
  input  logic             halt_on_early,
  input  logic [2:0]       w1c,
  output logic             stop_err,
  output logic             stop_early,
  output logic             irq_pend
);
  logic hit_err, hit_early, hit_irq;

  always_comb begin
    hit_err   = accept && halt_on_err && (err != '0);
    hit_early = accept && halt_on_early && early;
    hit_irq   = accept && (irq_done || ((err & err_mask) != '0));
  end

  // a new event in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      stop_err   <= 1'b0;
      stop_early <= 1'b0;
      irq_pend   <= 1'b0;
    end else begin
      stop_err   <= (stop_err   && !w1c[0]) || hit_err;
      stop_early <= (stop_early && !w1c[1]) || hit_early;
      irq_pend   <= (irq_pend   && !w1c[2]) || hit_irq;
    end
  end
endmodule

// File: rtl/dma_dispatch_csr.sv
module dma_dispatch_csr
  import dcsr_pkg::*;
#(
  parameter int RESP_DEPTH = 16,
  parameter int RST_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [DATA_W-1:0] cmp_bytes,
  input  logic [ERR_W-1:0]  cmp_err,
  input  logic              cmp_early,
  input  logic              cmp_irq_done,
  input  logic [ERR_W-1:0]  cmp_err_irq_mask,
  input  logic              mover_busy,
  input  logic              dq_empty,
  input  logic              dq_full,
  output logic              fetch_en,
  output logic              mover_rst,
  output logic              irq
);
  localparam int LVL_W = $clog2(RESP_DEPTH + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              resetting, rst_start;
  logic              wr_ctrl, wr_stat, accept, pop;
  logic              stop_err, stop_early, irq_pend, stopped;
  logic [2:0]        w1c;
  logic [LVL_W-1:0]  resp_level;
  logic              resp_empty, resp_full;
  resp_entry_t       resp_head, resp_new;
  logic [STAT_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat   = reg_wr && (reg_addr == A_STATUS);
  assign rst_start = wr_ctrl && reg_wdata[C_RESET] && !resetting;
  assign w1c       = wr_stat ? reg_wdata[S_IRQ:S_STOP_ERR] : 3'b000;

  assign cmp_ready = !resp_full && !resetting;
  assign accept    = cmp_valid && cmp_ready;
  assign pop       = reg_rd && (reg_addr == A_RSTAT) && !resp_empty && !resetting;

  assign resp_new.early = cmp_early;
  assign resp_new.err   = cmp_err;
  assign resp_new.bytes = cmp_bytes;

  // control word; starting a reset or running one leaves it zero
  always_ff @(posedge clk) begin
    if (rst || resetting) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      if (reg_wdata[C_RESET]) ctrl_q <= '0;
      else                    ctrl_q <= reg_wdata[CTRL_W-1:0];
    end
  end

  dcsr_reset_seq #(
    .CYCLES (RST_CYCLES)
  ) u_rst_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (rst_start),
    .active (resetting)
  );

  dcsr_resp_fifo #(
    .DEPTH (RESP_DEPTH),
    .LVL_W (LVL_W)
  ) u_resp_q (
    .clk   (clk),
    .rst   (rst),
    .flush (resetting),
    .push  (accept),
    .din   (resp_new),
    .pop   (pop),
    .head  (resp_head),
    .level (resp_level),
    .empty (resp_empty),
    .full  (resp_full)
  );

  dcsr_event_track u_events (
    .clk           (clk),
    .rst           (rst),
    .clear_all     (resetting),
    .accept        (accept),
    .err           (cmp_err),
    .early         (cmp_early),
    .irq_done      (cmp_irq_done),
    .err_mask      (cmp_err_irq_mask),
    .halt_on_err   (ctrl_q[C_STOP_ERR]),
    .halt_on_early (ctrl_q[C_STOP_ERLY]),
    .w1c           (w1c),
    .stop_err      (stop_err),
    .stop_early    (stop_early),
    .irq_pend      (irq_pend)
  );

  assign stopped   = ctrl_q[C_STOP] || stop_err || stop_early;
  assign fetch_en  = !stopped && !ctrl_q[C_HOLD_DESC] && !resetting;
  assign mover_rst = resetting;
  assign irq       = irq_pend && ctrl_q[C_GIE];

  always_comb begin
    status_w              = '0;
    status_w[S_BUSY]      = mover_busy;
    status_w[S_DQ_EMPTY]  = dq_empty;
    status_w[S_DQ_FULL]   = dq_full;
    status_w[S_RQ_EMPTY]  = resp_empty;
    status_w[S_RQ_FULL]   = resp_full;
    status_w[S_STOPPED]   = stopped;
    status_w[S_RESETTING] = resetting;
    status_w[S_STOP_ERR]  = stop_err;
    status_w[S_STOP_ERLY] = stop_early;
    status_w[S_IRQ]       = irq_pend;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_STATUS: rd_mux = DATA_W'(status_w);
      A_CTRL:   rd_mux = DATA_W'(ctrl_q);
      A_LEVEL:  rd_mux = DATA_W'(resp_level);
      A_RBYTES: if (!resp_empty) rd_mux = resp_head.bytes;
      A_RSTAT:  if (!resp_empty) rd_mux = DATA_W'({resp_head.early, resp_head.err});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_dispatch_csr_chk.sv
module dma_dispatch_csr_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_valid,
  input logic             cmp_ready,
  input logic             accept,
  input logic             pop,
  input logic             resetting,
  input logic             fetch_en,
  input logic             irq,
  input logic             irq_pend,
  input logic             stop_err,
  input logic             resp_full,
  input logic [LVL_W-1:0] level
);
  p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_full_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_full && cmp_valid) |-> !cmp_ready);

  p_pop_retires_r3: assert property (@(posedge clk) disable iff (rst)
    (pop && !accept) |=> (level == $past(level) - 1'b1));

  p_irq_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> $past(accept));

  p_err_halts_r7: assert property (@(posedge clk) disable iff (rst)
    stop_err |-> !fetch_en);

  p_reset_flushes_r10: assert property (@(posedge clk) disable iff (rst)
    resetting |=> (level == '0));

  p_no_irq_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
    resetting |=> !irq);
endmodule

bind dma_dispatch_csr dma_dispatch_csr_chk #(
  .DEPTH (RESP_DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cmp_ready (cmp_ready),
  .accept    (accept),
  .pop       (pop),
  .resetting (resetting),
  .fetch_en  (fetch_en),
  .irq       (irq),
  .irq_pend  (irq_pend),
  .stop_err  (stop_err),
  .resp_full (resp_full),
  .level     (resp_level)
);

// File: tb/test_dma_dispatch_csr.sv
module test_dma_dispatch_csr;
  localparam int DEPTH = 4;
  localparam int RSTC  = 6;
  localparam logic [2:0] A_ST = 3'd0, A_CT = 3'd1, A_LV = 3'd2, A_RB = 3'd3, A_RS = 3'd4;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmp_valid, cmp_ready;
  logic [31:0] cmp_bytes;
  logic [7:0]  cmp_err, cmp_err_irq_mask;
  logic        cmp_early, cmp_irq_done;
  logic        mover_busy, dq_empty, dq_full;
  logic        fetch_en, mover_rst, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_dispatch_csr #(.RESP_DEPTH(DEPTH), .RST_CYCLES(RSTC)) i_dma_dispatch_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_bytes(cmp_bytes), .cmp_err(cmp_err),
    .cmp_early(cmp_early), .cmp_irq_done(cmp_irq_done),
    .cmp_err_irq_mask(cmp_err_irq_mask), .mover_busy(mover_busy),
    .dq_empty(dq_empty), .dq_full(dq_full), .fetch_en(fetch_en),
    .mover_rst(mover_rst), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] b, input logic [7:0] e, input logic ea,
                      input logic idone, input logic [7:0] m);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_bytes = b; cmp_err = e; cmp_early = ea;
    cmp_irq_done = idone; cmp_err_irq_mask = m;
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) rd(A_RS, d);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(A_ST, d); chk("R1 status", d, 32'h008);
    rd(A_CT, d); chk("R1 control", d, 32'h0);
    rd(A_LV, d); chk("R1 level", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 fetch_en", 32'(fetch_en), 32'h1);
    chk("R1 cmp_ready", 32'(cmp_ready), 32'h1);
  endtask

  task automatic t_mirror();
    logic [31:0] d;
    mover_busy = 1'b1; dq_empty = 1'b1; dq_full = 1'b1;
    rd(A_ST, d); chk("R11 inputs high", d, 32'h00F);
    mover_busy = 1'b0; dq_full = 1'b0;
    rd(A_ST, d); chk("R11 dq_empty only", d, 32'h00A);
    dq_empty = 1'b0;
  endtask

  task automatic t_queue();
    logic [31:0] d;
    push(32'd100, 8'h00, 1'b0, 1'b0, 8'h00);
    push(32'd200, 8'h05, 1'b1, 1'b0, 8'h00);
    rd(A_LV, d); chk("R2 level two", d, 32'd2);
    rd(A_RB, d); chk("R2 first bytes", d, 32'd100);
    rd(A_RB, d); chk("R3 bytes reread", d, 32'd100);
    rd(A_LV, d); chk("R3 no pop on bytes", d, 32'd2);
    rd(A_RS, d); chk("R2 first status", d, 32'h000);
    rd(A_LV, d); chk("R3 level after pop", d, 32'd1);
    rd(A_RB, d); chk("R3 order bytes", d, 32'd200);
    rd(A_RS, d); chk("R2 err and early", d, 32'h105);
    rd(A_ST, d); chk("R3 queue empty", d, 32'h008);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push(32'd10 + 32'(i), 8'h00, 1'b0, 1'b0, 8'h00);
    rd(A_ST, d); chk("R4 full bit", d, 32'h010);
    chk("R4 cmp_ready low", 32'(cmp_ready), 32'h0);
    push(32'd99, 8'h00, 1'b0, 1'b0, 8'h00);
    rd(A_LV, d); chk("R4 level held", d, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RB, d); chk("R4 drain order", d, 32'd10 + 32'(i));
      rd(A_RS, d);
    end
    rd(A_ST, d); chk("R4 empty after drain", d, 32'h008);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    push(32'd1, 8'h00, 1'b0, 1'b1, 8'h00);
    rd(A_ST, d); chk("R5 pending on done", d, 32'h200);
    chk("R6 gated without enable", 32'(irq), 32'h0);
    wr(A_CT, 32'h10);
    chk("R6 irq with enable", 32'(irq), 32'h1);
    wr(A_ST, 32'h200);
    chk("R5 w1c drops irq", 32'(irq), 32'h0);
    rd(A_ST, d); chk("R5 pending cleared", d, 32'h000);
    push(32'd2, 8'h02, 1'b0, 1'b0, 8'h01);
    rd(A_ST, d); chk("R5 masked error", d, 32'h000);
    push(32'd3, 8'h02, 1'b0, 1'b0, 8'h02);
    rd(A_ST, d); chk("R5 unmasked error", d, 32'h200);
    chk("R6 irq on error", 32'(irq), 32'h1);
    wr(A_ST, 32'h200);
    drain(3);
    wr(A_CT, 32'h00);
  endtask

  task automatic t_stop_err();
    logic [31:0] d;
    push(32'd4, 8'h10, 1'b0, 1'b0, 8'h00);
    rd(A_ST, d); chk("R7 no halt when off", d, 32'h000);
    chk("R7 fetch kept", 32'(fetch_en), 32'h1);
    wr(A_CT, 32'h04);
    push(32'd5, 8'h10, 1'b0, 1'b0, 8'h00);
    rd(A_ST, d); chk("R7 halt bits", d, 32'h0A0);
    chk("R7 fetch off", 32'(fetch_en), 32'h0);
    wr(A_ST, 32'h080);
    rd(A_ST, d); chk("R7 released", d, 32'h000);
    chk("R7 fetch back", 32'(fetch_en), 32'h1);
    drain(2);
    wr(A_CT, 32'h00);
  endtask

  task automatic t_stop_early();
    logic [31:0] d;
    wr(A_CT, 32'h08);
    push(32'd6, 8'h00, 1'b1, 1'b0, 8'h00);
    rd(A_ST, d); chk("R8 early halt", d, 32'h120);
    chk("R8 fetch off", 32'(fetch_en), 32'h0);
    rd(A_RS, d); chk("R2 early flag word", d, 32'h100);
    wr(A_ST, 32'h100);
    rd(A_ST, d); chk("R8 cleared", d, 32'h008);
    wr(A_CT, 32'h00);
  endtask

  task automatic t_stop_ctrl();
    logic [31:0] d;
    wr(A_CT, 32'h01);
    rd(A_ST, d); chk("R9 stop bit", d, 32'h028);
    chk("R9 stop fetch", 32'(fetch_en), 32'h0);
    wr(A_CT, 32'h20);
    rd(A_ST, d); chk("R9 hold not stopped", d, 32'h008);
    chk("R9 hold fetch", 32'(fetch_en), 32'h0);
    rd(A_CT, d); chk("R9 readback", d, 32'h20);
    wr(A_CT, 32'h00);
    chk("R9 fetch resumes", 32'(fetch_en), 32'h1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    int hi;
    wr(A_CT, 32'h14);
    push(32'd7, 8'h01, 1'b0, 1'b1, 8'h00);
    push(32'd8, 8'h00, 1'b0, 1'b0, 8'h00);
    rd(A_ST, d); chk("R10 before reset", d, 32'h2A0);
    chk("R10 irq before", 32'(irq), 32'h1);
    wr(A_CT, 32'h02);
    chk("R10 cmp_ready low", 32'(cmp_ready), 32'h0);
    chk("R10 fetch low", 32'(fetch_en), 32'h0);
    hi = 0;
    for (int i = 0; i < RSTC + 3; i++) begin
      if (mover_rst) hi++;
      @(negedge clk);
    end
    chk("R10 reset length", 32'(hi), 32'(RSTC));
    rd(A_ST, d); chk("R10 status after", d, 32'h008);
    rd(A_CT, d); chk("R10 control after", d, 32'h0);
    rd(A_LV, d); chk("R10 flushed", d, 32'h0);
    chk("R10 irq after", 32'(irq), 32'h0);
    chk("R10 ready after", 32'(cmp_ready), 32'h1);
  endtask

  task automatic t_reset_flag();
    logic [31:0] d;
    wr(A_CT, 32'h02);
    rd(A_ST, d); chk("R10 resetting bit", (d >> 6) & 32'h1, 32'h1);
    repeat (RSTC + 2) @(negedge clk);
    rd(A_ST, d); chk("R10 resetting done", (d >> 6) & 32'h1, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cmp_valid = 1'b0; cmp_bytes = '0; cmp_err = '0; cmp_early = 1'b0;
    cmp_irq_done = 1'b0; cmp_err_irq_mask = '0;
    mover_busy = 1'b0; dq_empty = 1'b0; dq_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_mirror();
    t_queue();
    t_full();
    t_irq();
    t_stop_err();
    t_stop_early();
    t_stop_ctrl();
    t_soft_reset();
    t_reset_flag();
    finish_run();
  end
endmodule